// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This unit gathers single-cycle event pulses from an audio codec's analog and gain-control logic into a bank of sticky flags. It also gathers a change on the headphone-jack level. Software reads the flags, clears them by writing ones, and masks any of them from the single interrupt line. A two-bit form field selects whether that line is an active-high or active-low level, or an active-high or active-low one-cycle pulse.

Two addresses make up the register port. Address 0 is the flag register. Address 1 holds the mask bits and the form field. Reads are combinational from the selected register. Writes take effect at the next rising clock edge.

Top module: `codec_irq_unit`

## Requirements
- R1: After reset, the flag register reads 0x00 (with the jack input low), the mask register reads 0x3F (all sources masked, form 0), and `irq_o` is low.
- R2: A one-cycle high on `evt_i[n]` sets flag bit n at the next edge. The flag stays set until it is cleared. Bit meanings: 0 gain-down done, 1 gain-up done, 2 ramp-down done, 3 ramp-up done, 4 short-circuit.
- R3: Any change of `jack_i` between two consecutive clock edges sets flag bit 5. A rise and a fall both count.
- R4: Flag register bit 6 reads the current level of `jack_i`, is not sticky, and is not affected by writes. Bit 7 reads 0.
- R5: Writing the flag register (address 0) clears each of bits 5:0 written as 1. Bits written as 0 are left unchanged.
- R6: When a flag's set event and a write-one clear of that flag fall in the same cycle, the flag ends up set.
- R7: A 1 in mask bit n (bits 5:0, same order as the flags) keeps flag n off the interrupt. The flag still sets and reads normally.
- R8: With form field (mask register bits 7:6) = 0, `irq_o` is high exactly while some unmasked flag is set.
- R9: With form = 1, `irq_o` is low exactly while some unmasked flag is set, and high otherwise.
- R10: With form = 2, `irq_o` goes high for one cycle in the cycle after the set of unmasked pending flags goes from empty to non-empty. It is low at all other times.
- R11: With form = 3, `irq_o` goes low for one cycle under the same condition as R10. It is high at all other times.
- R12: The mask register (address 1) reads back all 8 bits last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 5 | Event pulses for flag bits 4:0 |
| jack_i | input | 1 | Headphone-jack detect level |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 = flags, 1 = mask/form |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Interrupt output, shaped by the form field |

## Verification
The assertions check on every cycle the following properties:
- a flag can fall only in a cycle where it was written as one;
- every event pulse leaves its flag set;
- a pending set of fully masked flags keeps the level-high output quiet;
- the level-low form inverts the pending state;
- a high pulse in form 2 never lasts two cycles.

The bench scenarios alone cover the remaining behaviour:
- the exact bit positions of each event;
- that jack edges in both directions count;
- the live jack bit;
- set winning over clear;
- the timing of the low pulse against a rising pending set.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;
  localparam int NUM_SRC  = 5;
  localparam int NUM_FLAG = NUM_SRC + 1;
  localparam int DW       = 8;
  localparam logic [DW-1:0] MASK_RST = 8'h3F;

  typedef enum logic [1:0] {
    FORM_HI_LVL   = 2'd0,
    FORM_LO_LVL   = 2'd1,
    FORM_HI_PULSE = 2'd2,
    FORM_LO_PULSE = 2'd3
  } irq_form_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC = 5,
  localparam int NF = NSRC + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            jack_i,
  input  logic [NF-1:0]   clr_i,
  output logic [NF-1:0]   flags_o
);
  logic          jack_q;
  logic [NF-1:0] set_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) jack_q <= 1'b0;
    else         jack_q <= jack_i;
  end

  assign set_w = {jack_i ^ jack_q, evt_i};

  for (genvar b = 0; b < NF; b++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_o[b] <= 1'b0;
      else if (set_w[b]) flags_o[b] <= 1'b1;  // set wins over clear
      else if (clr_i[b]) flags_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import codec_irq_pkg::*;
#(
  parameter int NF = NUM_FLAG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfg_o,
  output logic [NF-1:0] mask_o,
  output irq_form_e     form_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= MASK_RST;
    else if (we_i) cfg_o <= wdata_i;
  end

  assign mask_o = cfg_o[NF-1:0];
  assign form_o = irq_form_e'(cfg_o[DW-1:DW-2]);
endmodule

// File: rtl/irq_form_out.sv
module irq_form_out
  import codec_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  irq_form_e form_i,
  output logic      irq_o
);
  logic req_q, rise_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_i;
  end

  assign rise_w = req_i & ~req_q;

  always_comb begin
    unique case (form_i)
      FORM_HI_LVL:   irq_o = req_i;
      FORM_LO_LVL:   irq_o = ~req_i;
      FORM_HI_PULSE: irq_o = rise_w;
      FORM_LO_PULSE: irq_o = ~rise_w;
      default:       irq_o = req_i;
    endcase
  end
endmodule

// File: rtl/codec_irq_unit.sv
module codec_irq_unit
  import codec_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               jack_i,
  input  logic               wr_en_i,
  input  logic               addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o
);
  logic [NUM_FLAG-1:0] flags_q, clr_w, mask_w;
  logic [DW-1:0]       cfg_w;
  irq_form_e           form_w;
  logic                pend_w;

  assign clr_w = (wr_en_i && !addr_i) ? wdata_i[NUM_FLAG-1:0] : '0;

  irq_flag_bank #(.NSRC(NUM_SRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .jack_i (jack_i),
    .clr_i  (clr_w),
    .flags_o(flags_q)
  );

  irq_cfg_reg #(.NF(NUM_FLAG)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i && addr_i),
    .wdata_i(wdata_i),
    .cfg_o  (cfg_w),
    .mask_o (mask_w),
    .form_o (form_w)
  );

  assign pend_w = |(flags_q & ~mask_w);

  irq_form_out u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (pend_w),
    .form_i(form_w),
    .irq_o (irq_o)
  );

  assign rdata_o = addr_i ? cfg_w
                          : {{(DW-NUM_FLAG-1){1'b0}}, jack_i, flags_q};
endmodule

// File: rtl/codec_irq_unit_chk.sv
module codec_irq_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] evt_i,
  input logic       wr_en_i,
  input logic       addr_i,
  input logic [7:0] wdata_i,
  input logic [5:0] flags_q,
  input logic [7:0] cfg_w,
  input logic       irq_o
);
  logic [5:0] open_w;
  logic [1:0] form_w;
  assign open_w = flags_q & ~cfg_w[5:0];
  assign form_w = cfg_w[7:6];

  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags_q[4:0] & $past(evt_i)) == $past(evt_i)));

  a_r5_clear_only_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(flags_q) & ~flags_q)
      & ~(($past(wr_en_i) && !$past(addr_i)) ? $past(wdata_i[5:0]) : 6'd0)) == 6'd0));

  a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (form_w == 2'd0 && open_w == 6'd0) |-> !irq_o);

  a_r9_level_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (form_w == 2'd1) |-> (irq_o == (open_w == 6'd0)));

  a_r10_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (form_w == 2'd2 && irq_o) |=> (form_w != 2'd2 || !irq_o));
endmodule

bind codec_irq_unit codec_irq_unit_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .evt_i  (evt_i),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .flags_q(flags_q),
  .cfg_w  (cfg_w),
  .irq_o  (irq_o)
);

// File: tb/codec_irq_unit_test.sv
`timescale 1ns/1ps
module codec_irq_unit_test;
  logic       clk = 0, rst_n = 0;
  logic [4:0] evt = 0;
  logic       jack = 0, wr = 0, addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       irq;

  int    errors = 0, checks = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference state
  int m_flags = 0, m_mask = 'h3F, m_prev_any = 0, m_jack_prev = 0;

  always #2.5 clk = ~clk;

  codec_irq_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .jack_i(jack),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = 0; m_mask = 'h3F; m_prev_any = 0; m_jack_prev = 0;
    end else begin
      int any_now, setv, clrv;
      any_now = ((m_flags & ~m_mask & 'h3F) != 0);
      setv = evt | (((jack ? 1 : 0) != m_jack_prev) ? 'h20 : 0);
      clrv = (wr && !addr) ? (wdata & 'h3F) : 0;
      m_flags = ((m_flags & ~clrv) | setv) & 'h3F;
      if (wr && addr) m_mask = wdata;
      m_prev_any = any_now;
      m_jack_prev = jack ? 1 : 0;
    end
  end

  function automatic int exp_irq();
    int any, rise;
    any  = ((m_flags & ~m_mask & 'h3F) != 0);
    rise = any && !m_prev_any;
    case ((m_mask >> 6) & 3)
      0: return any;
      1: return !any;
      2: return rise;
      default: return !rise;
    endcase
  endfunction

  function automatic int exp_rd();
    if (addr) return m_mask & 'hFF;
    return m_flags | (jack ? 'h40 : 0);
  endfunction

  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk); #1;
      if (done) break;
      checks++;
      if (irq !== exp_irq()[0]) begin
        errors++;
        $display("FAIL %s irq_o actual=%0b expected=%0b t=%0t", cur_req, irq, exp_irq(), $time);
      end
      checks++;
      if (rdata !== exp_rd()) begin
        errors++;
        $display("FAIL %s rdata_o actual=%02h expected=%02h t=%0t", cur_req, rdata, exp_rd(), $time);
      end
    end
  end

  task automatic cyc(input logic [4:0] e, input logic w, input logic a, input logic [7:0] d);
    @(negedge clk);
    evt = e; wr = w; addr = a; wdata = d;
  endtask

  task automatic idle(input int n, input logic a);
    for (int i = 0; i < n; i++) cyc(5'd0, 1'b0, a, 8'h00);
  endtask

  initial begin
    #12 rst_n = 1;
    cur_req = "R1"; idle(2, 0); idle(2, 1);
    cur_req = "R12"; cyc(0, 1, 1, 8'h00); idle(1, 1); cyc(0, 1, 1, 8'h15); idle(1, 1);
    cyc(0, 1, 1, 8'h00); idle(1, 0);
    for (int b = 0; b < 5; b++) begin
      cur_req = "R2"; cyc(5'(1 << b), 0, 0, 0); idle(2, 0);
      cur_req = "R8"; idle(1, 0);
    end
    cur_req = "R5"; cyc(0, 1, 0, 8'h00); idle(1, 0);
    cyc(0, 1, 0, 8'h05); idle(1, 0); cyc(0, 1, 0, 8'hFF); idle(2, 0);
    cur_req = "R3"; @(negedge clk) jack = 1; idle(2, 0);
    cur_req = "R4"; cyc(0, 1, 0, 8'h60); idle(2, 0);
    cur_req = "R3"; @(negedge clk) jack = 0; idle(2, 0); cyc(0, 1, 0, 8'h20); idle(1, 0);
    cur_req = "R6"; cyc(5'h01, 1, 0, 8'h01); idle(2, 0); cyc(0, 1, 0, 8'h3F); idle(1, 0);
    cur_req = "R7"; cyc(0, 1, 1, 8'h01); cyc(5'h01, 0, 0, 0); idle(3, 0);
    cyc(5'h02, 0, 0, 0); idle(2, 0);
    cur_req = "R9"; cyc(0, 1, 1, 8'h40); idle(2, 0); cyc(0, 1, 0, 8'h3F); idle(2, 0);
    cyc(5'h10, 0, 0, 0); idle(2, 0); cyc(0, 1, 0, 8'h3F); idle(1, 0);
    cur_req = "R10"; cyc(0, 1, 1, 8'h80); idle(1, 0); cyc(5'h08, 0, 0, 0); idle(4, 0);
    cyc(0, 1, 0, 8'h3F); idle(1, 0); @(negedge clk) jack = 1; idle(3, 0);
    cyc(0, 1, 0, 8'h3F); idle(1, 0);
    cur_req = "R11"; cyc(0, 1, 1, 8'hC0); idle(1, 0); cyc(5'h04, 0, 0, 0); idle(4, 0);
    cyc(0, 1, 0, 8'h3F); idle(1, 0); cyc(5'h03, 0, 0, 0); idle(3, 0);
    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      evt = 5'($urandom_range(0, 31) & $urandom_range(0, 31) & $urandom_range(0, 31));
      wr = ($urandom_range(0, 3) == 0); addr = 1'($urandom_range(0, 1));
      wdata = 8'($urandom_range(0, 255)); jack = ($urandom_range(0, 15) == 0) ? ~jack : jack;
    end
    idle(2, 0);
    done = 1;
    @(posedge clk); #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule